// File: doc/BRIEF.md
# Synchronous Dual-Port Burst RAM

This block is a true dual-port static memory of 4096 words of 18 bits. Both ports share one clock and work independently, so each can read or write any word in any cycle, including the same word as the other port. Each port also has its own burst address counter, so a master can give one starting address and then walk through consecutive words without driving the address bus again.

In a cycle, a port's counter control picks the word it accesses. The choices are address 0, the external address, the word after the counter, or the counter itself. The word chosen becomes the new counter value. A port is active only when its active-low enable is low and its active-high enable is high. Two active-low lane controls split the word into an upper lane (bits 17:9) and a lower lane (bits 8:0). A per-port mode input picks flow-through or pipelined read latency, and an active-low output enable masks only what the port shows.

Top module: `dual_port_burst_ram`

## Requirements
- R1: When `x_clr_n` is low, the port accesses word 0 and its counter becomes 0 in that cycle, whatever the other counter controls are.
- R2: When `x_clr_n` is high and `x_ld_n` is low, the port accesses `x_addr` and the counter takes that value.
- R3: When `x_clr_n` and `x_ld_n` are high and `x_inc_n` is low, the port accesses counter+1 and the counter takes that value. The increment wraps from 4095 to 0.
- R4: When all three counter controls are high, the port accesses the word held in the counter again, and the counter keeps its value.
- R5: A port is selected only when `x_ce0_n`=0 and `x_ce1`=1. A port that is not selected does not write memory, and the read result it shows for that cycle has `x_dvalid`=0 and `x_dout`=0.
- R6: A selected port with `x_we_n`=0 writes bits 17:9 only if `x_ub_n`=0, and bits 8:0 only if `x_lb_n`=0. Memory bits in a lane that is turned off keep their old value.
- R7: A selected port with `x_we_n`=1 performs a read. Its result has `x_dvalid`=1, and the data bits in any lane whose control is high read as 0.
- R8: With `x_pipe`=0, a read result appears on `x_dout`/`x_dvalid` right after the rising edge that takes the request.
- R9: With `x_pipe`=1, the result appears one clock edge later than with `x_pipe`=0.
- R10: When both ports write the same word in the same cycle, port A's lanes win. Any lane that only port B writes takes port B's data.
- R11: A read by one port of a word that the other port writes in the same cycle returns the data the word held before that write.
- R12: While `x_oe_n`=1, `x_dout` is 0 and `x_dvalid` is 0. Output enable has no effect on memory contents, on the counter, or on the read results lined up behind it.
- R13: During and right after reset (`rst_n` low, asynchronous), both counters are 0 and both ports show `x_dvalid`=0 and `x_dout`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| a_addr | input | 12 | Port A external address |
| a_ld_n | input | 1 | Port A load external address, active low |
| a_inc_n | input | 1 | Port A counter increment, active low |
| a_clr_n | input | 1 | Port A counter clear, active low |
| a_ce0_n | input | 1 | Port A enable, active low |
| a_ce1 | input | 1 | Port A enable, active high |
| a_we_n | input | 1 | Port A write (0) or read (1) |
| a_ub_n | input | 1 | Port A upper lane (17:9) enable, active low |
| a_lb_n | input | 1 | Port A lower lane (8:0) enable, active low |
| a_oe_n | input | 1 | Port A output enable, active low |
| a_pipe | input | 1 | Port A latency: 0 flow-through, 1 pipelined |
| a_din | input | 18 | Port A write data |
| a_dout | output | 18 | Port A read data |
| a_dvalid | output | 1 | Port A read data valid |
| b_addr | input | 12 | Port B external address |
| b_ld_n | input | 1 | Port B load external address, active low |
| b_inc_n | input | 1 | Port B counter increment, active low |
| b_clr_n | input | 1 | Port B counter clear, active low |
| b_ce0_n | input | 1 | Port B enable, active low |
| b_ce1 | input | 1 | Port B enable, active high |
| b_we_n | input | 1 | Port B write (0) or read (1) |
| b_ub_n | input | 1 | Port B upper lane enable, active low |
| b_lb_n | input | 1 | Port B lower lane enable, active low |
| b_oe_n | input | 1 | Port B output enable, active low |
| b_pipe | input | 1 | Port B latency: 0 flow-through, 1 pipelined |
| b_din | input | 18 | Port B write data |
| b_dout | output | 18 | Port B read data |
| b_dvalid | output | 1 | Port B read data valid |

## Verification
The counter properties assume that all inputs are known on every rising edge after reset, so that the counter priority gives exactly one outcome. The deselect property assumes that the latency mode does not change between a deselected cycle and the cycle that follows it. The stimulus changes the mode only at block boundaries many cycles apart, so the mode seldom changes in the cycle right after a deselect. The random stimulus keeps addresses inside two small windows, one at each end of the address space. This forces frequent same-word collisions between the ports and frequent counter wraps, and a fill pass writes every word first so that no read returns uninitialised data.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
    localparam int LANES = 2;

    typedef enum logic [1:0] {
        CTR_HOLD = 2'd0,
        CTR_INC  = 2'd1,
        CTR_LOAD = 2'd2,
        CTR_CLR  = 2'd3
    } ctr_op_e;
endpackage

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl
    import dpr_pkg::*;
#(
    parameter int AW = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    ext_addr,
    input  logic             ld_n,
    input  logic             inc_n,
    input  logic             clr_n,
    input  logic             ce0_n,
    input  logic             ce1,
    input  logic             we_n,
    input  logic             ub_n,
    input  logic             lb_n,
    output logic [AW-1:0]    acc_addr,
    output logic [LANES-1:0] wr_lanes,
    output logic [LANES-1:0] rd_lanes,
    output logic             rd_en,
    output logic [AW-1:0]    cnt
);
    typedef struct packed {
        logic [AW-1:0] cnt;
    } ctr_st_t;

    ctr_st_t   st_d, st_q;
    ctr_op_e   op;
    logic      sel;
    logic [LANES-1:0] lane_on;

    always_comb begin
        // priority: clear, load, increment, hold
        if (!clr_n)      op = CTR_CLR;
        else if (!ld_n)  op = CTR_LOAD;
        else if (!inc_n) op = CTR_INC;
        else             op = CTR_HOLD;

        st_d = st_q;
        unique case (op)
            CTR_CLR:  st_d.cnt = '0;
            CTR_LOAD: st_d.cnt = ext_addr;
            CTR_INC:  st_d.cnt = st_q.cnt + AW'(1);
            default:  st_d.cnt = st_q.cnt;
        endcase

        sel      = !ce0_n && ce1;
        lane_on  = {!ub_n, !lb_n};
        acc_addr = st_d.cnt;
        rd_en    = sel && we_n;
        wr_lanes = (sel && !we_n) ? lane_on : '0;
        rd_lanes = lane_on;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;
endmodule

// File: rtl/dpr_mem_core.sv
module dpr_mem_core
    import dpr_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 18
) (
    input  logic             clk,
    input  logic [AW-1:0]    a_addr,
    input  logic [LANES-1:0] a_wr,
    input  logic             a_rd,
    input  logic [DW-1:0]    a_din,
    output logic [DW-1:0]    a_rdata,
    input  logic [AW-1:0]    b_addr,
    input  logic [LANES-1:0] b_wr,
    input  logic             b_rd,
    input  logic [DW-1:0]    b_din,
    output logic [DW-1:0]    b_rdata
);
    localparam int DEPTH = 1 << AW;
    localparam int LW    = DW / LANES;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LW-1:0] store [DEPTH];
        logic [LW-1:0] a_q, b_q;

        always_ff @(posedge clk) begin
            // port B first so that port A overrides on a shared word
            if (b_wr[g]) store[b_addr] <= b_din[g*LW +: LW];
            if (a_wr[g]) store[a_addr] <= a_din[g*LW +: LW];
            if (a_rd)    a_q <= store[a_addr];
            if (b_rd)    b_q <= store[b_addr];
        end

        assign a_rdata[g*LW +: LW] = a_q;
        assign b_rdata[g*LW +: LW] = b_q;
    end
endmodule

// File: rtl/dpr_read_out.sv
module dpr_read_out
    import dpr_pkg::*;
#(
    parameter int DW = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [LANES-1:0] rd_lanes,
    input  logic [DW-1:0]    rdata,
    input  logic             pipe,
    input  logic             oe_n,
    output logic [DW-1:0]    dout,
    output logic             dvalid
);
    localparam int LW = DW / LANES;

    typedef struct packed {
        logic             v1;
        logic [LANES-1:0] m1;
        logic             v2;
        logic [DW-1:0]    d2;
    } out_st_t;

    out_st_t        st_d, st_q;
    logic [DW-1:0]  s1_data;
    logic [DW-1:0]  sel_data;
    logic           sel_valid;

    always_comb begin
        for (int g = 0; g < LANES; g++) begin
            s1_data[g*LW +: LW] = (st_q.v1 && st_q.m1[g]) ? rdata[g*LW +: LW] : '0;
        end

        st_d    = st_q;
        st_d.v1 = rd_en;
        st_d.m1 = rd_lanes;
        st_d.v2 = st_q.v1;
        st_d.d2 = s1_data;

        sel_valid = pipe ? st_q.v2 : st_q.v1;
        sel_data  = pipe ? st_q.d2 : s1_data;
        dvalid    = !oe_n && sel_valid;
        dout      = oe_n ? '0 : sel_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/dual_port_burst_ram.sv
module dual_port_burst_ram
    import dpr_pkg::*;
#(
    parameter int AW = 12,
    parameter int DW = 18
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] a_addr,
    input  logic          a_ld_n,
    input  logic          a_inc_n,
    input  logic          a_clr_n,
    input  logic          a_ce0_n,
    input  logic          a_ce1,
    input  logic          a_we_n,
    input  logic          a_ub_n,
    input  logic          a_lb_n,
    input  logic          a_oe_n,
    input  logic          a_pipe,
    input  logic [DW-1:0] a_din,
    output logic [DW-1:0] a_dout,
    output logic          a_dvalid,
    input  logic [AW-1:0] b_addr,
    input  logic          b_ld_n,
    input  logic          b_inc_n,
    input  logic          b_clr_n,
    input  logic          b_ce0_n,
    input  logic          b_ce1,
    input  logic          b_we_n,
    input  logic          b_ub_n,
    input  logic          b_lb_n,
    input  logic          b_oe_n,
    input  logic          b_pipe,
    input  logic [DW-1:0] b_din,
    output logic [DW-1:0] b_dout,
    output logic          b_dvalid
);
    localparam int NP = 2;

    logic [AW-1:0]    p_addr  [NP];
    logic             p_ld_n  [NP];
    logic             p_inc_n [NP];
    logic             p_clr_n [NP];
    logic             p_ce0_n [NP];
    logic             p_ce1   [NP];
    logic             p_we_n  [NP];
    logic             p_ub_n  [NP];
    logic             p_lb_n  [NP];
    logic             p_oe_n  [NP];
    logic             p_pipe  [NP];
    logic [DW-1:0]    p_din   [NP];
    logic [DW-1:0]    p_dout  [NP];
    logic             p_dval  [NP];
    logic [AW-1:0]    p_acc   [NP];
    logic [LANES-1:0] p_wr    [NP];
    logic [LANES-1:0] p_rdl   [NP];
    logic             p_rd    [NP];
    logic [AW-1:0]    p_cnt   [NP];
    logic [DW-1:0]    p_rdata [NP];
    logic [AW-1:0]    cnt_a, cnt_b;

    assign p_addr[0]  = a_addr;   assign p_addr[1]  = b_addr;
    assign p_ld_n[0]  = a_ld_n;   assign p_ld_n[1]  = b_ld_n;
    assign p_inc_n[0] = a_inc_n;  assign p_inc_n[1] = b_inc_n;
    assign p_clr_n[0] = a_clr_n;  assign p_clr_n[1] = b_clr_n;
    assign p_ce0_n[0] = a_ce0_n;  assign p_ce0_n[1] = b_ce0_n;
    assign p_ce1[0]   = a_ce1;    assign p_ce1[1]   = b_ce1;
    assign p_we_n[0]  = a_we_n;   assign p_we_n[1]  = b_we_n;
    assign p_ub_n[0]  = a_ub_n;   assign p_ub_n[1]  = b_ub_n;
    assign p_lb_n[0]  = a_lb_n;   assign p_lb_n[1]  = b_lb_n;
    assign p_oe_n[0]  = a_oe_n;   assign p_oe_n[1]  = b_oe_n;
    assign p_pipe[0]  = a_pipe;   assign p_pipe[1]  = b_pipe;
    assign p_din[0]   = a_din;    assign p_din[1]   = b_din;

    for (genvar p = 0; p < NP; p++) begin : g_port
        dpr_port_ctrl #(.AW(AW)) u_ctrl (
            .clk      (clk),
            .rst_n    (rst_n),
            .ext_addr (p_addr[p]),
            .ld_n     (p_ld_n[p]),
            .inc_n    (p_inc_n[p]),
            .clr_n    (p_clr_n[p]),
            .ce0_n    (p_ce0_n[p]),
            .ce1      (p_ce1[p]),
            .we_n     (p_we_n[p]),
            .ub_n     (p_ub_n[p]),
            .lb_n     (p_lb_n[p]),
            .acc_addr (p_acc[p]),
            .wr_lanes (p_wr[p]),
            .rd_lanes (p_rdl[p]),
            .rd_en    (p_rd[p]),
            .cnt      (p_cnt[p])
        );

        dpr_read_out #(.DW(DW)) u_out (
            .clk      (clk),
            .rst_n    (rst_n),
            .rd_en    (p_rd[p]),
            .rd_lanes (p_rdl[p]),
            .rdata    (p_rdata[p]),
            .pipe     (p_pipe[p]),
            .oe_n     (p_oe_n[p]),
            .dout     (p_dout[p]),
            .dvalid   (p_dval[p])
        );
    end

    dpr_mem_core #(.AW(AW), .DW(DW)) u_mem (
        .clk     (clk),
        .a_addr  (p_acc[0]),
        .a_wr    (p_wr[0]),
        .a_rd    (p_rd[0]),
        .a_din   (p_din[0]),
        .a_rdata (p_rdata[0]),
        .b_addr  (p_acc[1]),
        .b_wr    (p_wr[1]),
        .b_rd    (p_rd[1]),
        .b_din   (p_din[1]),
        .b_rdata (p_rdata[1])
    );

    assign a_dout   = p_dout[0];
    assign a_dvalid = p_dval[0];
    assign b_dout   = p_dout[1];
    assign b_dvalid = p_dval[1];
    assign cnt_a    = p_cnt[0];
    assign cnt_b    = p_cnt[1];
endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
    parameter int AW = 12,
    parameter int DW = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] a_addr,
    input logic          a_ld_n,
    input logic          a_inc_n,
    input logic          a_clr_n,
    input logic          a_ce0_n,
    input logic          a_ce1,
    input logic          a_oe_n,
    input logic          a_pipe,
    input logic [DW-1:0] a_dout,
    input logic          a_dvalid,
    input logic [AW-1:0] cnt_a,
    input logic [AW-1:0] b_addr,
    input logic          b_ld_n,
    input logic          b_inc_n,
    input logic          b_clr_n,
    input logic          b_oe_n,
    input logic [DW-1:0] b_dout,
    input logic          b_dvalid,
    input logic [AW-1:0] cnt_b
);
    assert_a_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !a_clr_n |=> cnt_a == '0);
    assert_b_clear_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !b_clr_n |=> cnt_b == '0);
    assert_a_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (a_clr_n && !a_ld_n) |=> cnt_a == $past(a_addr));
    assert_b_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (b_clr_n && !b_ld_n) |=> cnt_b == $past(b_addr));
    assert_a_incr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (a_clr_n && a_ld_n && !a_inc_n) |=> cnt_a == AW'($past(cnt_a) + AW'(1)));
    assert_b_incr_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (b_clr_n && b_ld_n && !b_inc_n) |=> cnt_b == AW'($past(cnt_b) + AW'(1)));
    assert_a_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (a_clr_n && a_ld_n && a_inc_n) |=> $stable(cnt_a));
    assert_b_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (b_clr_n && b_ld_n && b_inc_n) |=> $stable(cnt_b));
    assert_a_deselect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!(!a_ce0_n && a_ce1) && !a_pipe) |=> (a_pipe || !a_dvalid));
    assert_a_oe_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        a_oe_n |-> (!a_dvalid && a_dout == '0));
    assert_b_oe_mask_R12: assert property (@(posedge clk) disable iff (!rst_n)
        b_oe_n |-> (!b_dvalid && b_dout == '0));
endmodule

bind dual_port_burst_ram dpr_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .a_addr   (a_addr),
    .a_ld_n   (a_ld_n),
    .a_inc_n  (a_inc_n),
    .a_clr_n  (a_clr_n),
    .a_ce0_n  (a_ce0_n),
    .a_ce1    (a_ce1),
    .a_oe_n   (a_oe_n),
    .a_pipe   (a_pipe),
    .a_dout   (a_dout),
    .a_dvalid (a_dvalid),
    .cnt_a    (cnt_a),
    .b_addr   (b_addr),
    .b_ld_n   (b_ld_n),
    .b_inc_n  (b_inc_n),
    .b_clr_n  (b_clr_n),
    .b_oe_n   (b_oe_n),
    .b_dout   (b_dout),
    .b_dvalid (b_dvalid),
    .cnt_b    (cnt_b)
);

// File: tb/dual_port_burst_ram_test.sv
module dual_port_burst_ram_test;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n;
    logic [11:0] addr  [2];
    logic        ld_n  [2];
    logic        inc_n [2];
    logic        clr_n [2];
    logic        ce0_n [2];
    logic        ce1   [2];
    logic        we_n  [2];
    logic        ub_n  [2];
    logic        lb_n  [2];
    logic        oe_n  [2];
    logic        pipe  [2];
    logic [17:0] din   [2];
    logic [17:0] dout  [2];
    logic        dvalid[2];

    logic [17:0] mm   [4096];
    logic [11:0] mcnt [2];
    logic        s1v  [2];
    logic        s2v  [2];
    logic [17:0] s1d  [2];
    logic [17:0] s2d  [2];

    int errs = 0;
    int checks = 0;
    bit done = 1'b0;

    dual_port_burst_ram uut (
        .clk(clk), .rst_n(rst_n),
        .a_addr(addr[0]), .a_ld_n(ld_n[0]), .a_inc_n(inc_n[0]), .a_clr_n(clr_n[0]),
        .a_ce0_n(ce0_n[0]), .a_ce1(ce1[0]), .a_we_n(we_n[0]), .a_ub_n(ub_n[0]),
        .a_lb_n(lb_n[0]), .a_oe_n(oe_n[0]), .a_pipe(pipe[0]), .a_din(din[0]),
        .a_dout(dout[0]), .a_dvalid(dvalid[0]),
        .b_addr(addr[1]), .b_ld_n(ld_n[1]), .b_inc_n(inc_n[1]), .b_clr_n(clr_n[1]),
        .b_ce0_n(ce0_n[1]), .b_ce1(ce1[1]), .b_we_n(we_n[1]), .b_ub_n(ub_n[1]),
        .b_lb_n(lb_n[1]), .b_oe_n(oe_n[1]), .b_pipe(pipe[1]), .b_din(din[1]),
        .b_dout(dout[1]), .b_dvalid(dvalid[1])
    );

    function automatic logic [17:0] hv(int a);
        return 18'((a * 37) ^ 18'h2A5C3);
    endfunction

    function automatic logic [17:0] lmask(logic u_n, logic l_n);
        return {{9{~u_n}}, {9{~l_n}}};
    endfunction

    task automatic chk(string tag, logic [18:0] got, logic [18:0] exp);
        checks++;
        if (got !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    task automatic idle(int p);
        ce0_n[p] = 1'b1; ce1[p] = 1'b0; ld_n[p] = 1'b1; inc_n[p] = 1'b1;
        clr_n[p] = 1'b1; we_n[p] = 1'b1; ub_n[p] = 1'b0; lb_n[p] = 1'b0;
        oe_n[p] = 1'b0; addr[p] = '0; din[p] = '0;
    endtask

    task automatic sel(int p, logic w);
        ce0_n[p] = 1'b0; ce1[p] = 1'b1; we_n[p] = w;
        ld_n[p] = 1'b1; inc_n[p] = 1'b1; clr_n[p] = 1'b1;
    endtask

    task automatic model_edge();
        logic [11:0] ea [2];
        logic        rv [2];
        logic [17:0] rd [2];
        for (int p = 0; p < 2; p++) begin
            logic s;
            s = !ce0_n[p] && ce1[p];
            if (!clr_n[p])      ea[p] = '0;
            else if (!ld_n[p])  ea[p] = addr[p];
            else if (!inc_n[p]) ea[p] = mcnt[p] + 12'd1;
            else                ea[p] = mcnt[p];
            mcnt[p] = ea[p];
            rv[p] = s && we_n[p];
            rd[p] = rv[p] ? (mm[ea[p]] & lmask(ub_n[p], lb_n[p])) : '0;
        end
        for (int p = 1; p >= 0; p--) begin
            if (!ce0_n[p] && ce1[p] && !we_n[p]) begin
                logic [17:0] m;
                m = lmask(ub_n[p], lb_n[p]);
                mm[ea[p]] = (mm[ea[p]] & ~m) | (din[p] & m);
            end
        end
        for (int p = 0; p < 2; p++) begin
            s2v[p] = s1v[p]; s2d[p] = s1d[p];
            s1v[p] = rv[p];  s1d[p] = rd[p];
        end
    endtask

    task automatic step(string tag);
        @(posedge clk);
        model_edge();
        #2;
        for (int p = 0; p < 2; p++) begin
            logic [18:0] e;
            e = oe_n[p] ? 19'd0 : (pipe[p] ? {s2v[p], s2d[p]} : {s1v[p], s1d[p]});
            chk($sformatf("%s port%0d", tag, p), {dvalid[p], dout[p]}, e);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL R13 watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < 4096; i++) mm[i] = '0;
        for (int p = 0; p < 2; p++) begin
            idle(p); pipe[p] = 1'b0;
            mcnt[p] = '0; s1v[p] = 0; s2v[p] = 0; s1d[p] = '0; s2d[p] = '0;
        end
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R13: outputs quiet in reset
        chk("R13 reset port0", {dvalid[0], dout[0]}, 19'd0);
        chk("R13 reset port1", {dvalid[1], dout[1]}, 19'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R13/R4: counter starts at 0, hold reads word 0 (still zero data in model only after fill)
        // fill all words through port A: clear then increment, wraps at the end
        sel(0, 1'b0); clr_n[0] = 1'b0; din[0] = hv(0);
        step("R1 R6 fill");
        for (int i = 1; i < 4096; i++) begin
            sel(0, 1'b0); inc_n[0] = 1'b0; din[0] = hv(i);
            step("R3 R6 fill");
        end
        // R3 wrap and R8 flow-through latency
        sel(0, 1'b1); inc_n[0] = 1'b0;
        step("R3 wrap");
        chk("R3 wrap to 0 / R8 flow", {dvalid[0], dout[0]}, {1'b1, hv(0)});

        // R9 pipelined latency
        pipe[0] = 1'b1; idle(0);
        step("R9 flush"); step("R9 flush");
        sel(0, 1'b1); ld_n[0] = 1'b0; addr[0] = 12'd7;
        step("R9 issue");
        chk("R9 not yet", {dvalid[0], dout[0]}, 19'd0);
        idle(0);
        step("R9 late");
        chk("R9 one edge later", {dvalid[0], dout[0]}, {1'b1, hv(7)});
        pipe[0] = 1'b0;
        step("R9 back");

        // R4 hold: load 9, then hold re-reads 9
        sel(0, 1'b1); ld_n[0] = 1'b0; addr[0] = 12'd9;
        step("R2 load");
        sel(0, 1'b1);
        step("R4 hold");
        chk("R4 hold", {dvalid[0], dout[0]}, {1'b1, hv(9)});

        // R10 same-word write collision
        sel(0, 1'b0); ld_n[0] = 1'b0; addr[0] = 12'd5; din[0] = 18'h11111;
        sel(1, 1'b0); ld_n[1] = 1'b0; addr[1] = 12'd5; din[1] = 18'h22222;
        step("R10 collide");
        idle(1); sel(0, 1'b1);
        step("R10 readback");
        chk("R10 A wins", {dvalid[0], dout[0]}, {1'b1, 18'h11111});

        // R11 read-during-write returns old data
        sel(0, 1'b0); ld_n[0] = 1'b0; addr[0] = 12'd6; din[0] = 18'h03333;
        sel(1, 1'b1); ld_n[1] = 1'b0; addr[1] = 12'd6;
        step("R11 rdw");
        chk("R11 old data", {dvalid[1], dout[1]}, {1'b1, hv(6)});
        idle(0); sel(1, 1'b1);
        step("R11 new");
        chk("R11 new data", {dvalid[1], dout[1]}, {1'b1, 18'h03333});

        // R7 lane gating on read
        idle(1); sel(0, 1'b1); ub_n[0] = 1'b1;
        step("R7 lane");
        chk("R7 upper off", {dvalid[0], dout[0]}, {1'b1, 18'h03333 & 18'h001FF});
        ub_n[0] = 1'b0;

        // R5 deselected write has no effect
        ce0_n[0] = 1'b0; ce1[0] = 1'b0; we_n[0] = 1'b0; din[0] = 18'h3FFFF;
        step("R5 desel");
        chk("R5 no valid", {dvalid[0], dout[0]}, 19'd0);
        sel(0, 1'b1);
        step("R5 intact");
        chk("R5 data kept", {dvalid[0], dout[0]}, {1'b1, 18'h03333});

        // R12 output enable masks only the visible output
        oe_n[0] = 1'b1;
        step("R12 masked");
        chk("R12 masked", {dvalid[0], dout[0]}, 19'd0);
        oe_n[0] = 1'b0; idle(0);
        #1;
        chk("R12 unmasked", {dvalid[0], dout[0]}, {1'b1, 18'h03333});
        step("R12 idle");

        // constrained random on both ports
        for (int i = 0; i < 3000; i++) begin
            if (i % 250 == 0) begin
                pipe[0] = 1'($urandom % 2);
                pipe[1] = 1'($urandom % 2);
            end
            for (int p = 0; p < 2; p++) begin
                addr[p]  = ($urandom % 2) ? 12'($urandom % 8) : 12'(12'hFF8 + $urandom % 8);
                clr_n[p] = ($urandom % 16) != 0;
                ld_n[p]  = ($urandom % 4) != 0;
                inc_n[p] = ($urandom % 2) != 0;
                ce0_n[p] = ($urandom % 8) == 0;
                ce1[p]   = ($urandom % 8) != 0;
                we_n[p]  = ($urandom % 3) != 0;
                ub_n[p]  = ($urandom % 4) == 0;
                lb_n[p]  = ($urandom % 4) == 0;
                oe_n[p]  = ($urandom % 8) == 0;
                din[p]   = 18'($urandom);
            end
            step("rand R1 R2 R3 R4 R6 R7 R10 R11");
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule